// File: doc/BRIEF.md
# Network Interface Interrupt Controller

This block collects interrupt causes from the receive and transmit paths of a network interface and turns them into one interrupt line for the processor. Each cause arrives as a one-cycle pulse on `cause_i`. The pulse is held in a sticky status register. The status is ANDed with a mask register, and the line is driven whenever this pending set is non-empty and the global enable is on.

Two watermark causes use hysteresis. The receive-high cause is accepted only after the receive-empty cause has been seen since it was last accepted. The transmit-low cause is accepted only after the transmit-full cause has been seen since it was last accepted. In both cases, accepting the cause uses up the arming. This means a FIFO that hovers around its threshold does not raise an interrupt storm.

Causes in the urgent class raise the line on the next clock edge. Other causes wait for a programmable coalescing delay. Software reaches the block through a small register port. It reads status to collect and clear it, and it writes a command word to raise a software cause or to reset the block.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset, config reads 0, status reads 0, mask reads 0x047, delay reads its reset value (8), and `irq_o` is low. Register addresses are: config 0 (bit 0 is the global enable), status 1, mask 2, command 3, delay 4.
- R2: A pulse on `cause_i[k]` sets status bit k. Reading address 1 returns the status and clears it. A pulse that arrives in the same cycle as that read is kept and is returned by the next read.
- R3: A write to address 1 clears exactly the status bits that are written as one and are set. Every other status bit is kept.
- R4: The pending set is status AND mask. `irq_o` is raised only for a non-empty pending set while config bit 0 is 1. Clearing config bit 0 drops `irq_o` one edge later and leaves status unchanged.
- R5: The receive-high cause (bit 2) is latched only if the receive-empty cause (bit 3) has pulsed since bit 2 was last latched. After a reset the receive-high cause is disarmed.
- R6: The transmit-low cause (bit 6) is latched only if the transmit-full cause (bit 7) has pulsed since bit 6 was last latched. After a reset the transmit-low cause is disarmed.
- R7: If a pending cause is in the urgent class (by default only the software cause, bit 0), `irq_o` rises on the first edge after the status bit appears.
- R8: If the pending set holds no urgent cause, `irq_o` rises D+1 edges after the edge that latched the status bit, where D is the delay register value.
- R9: New non-urgent causes do not restart a running delay. An urgent cause that arrives during the delay raises `irq_o` on the next edge.
- R10: Writing the command register with bit 0 set raises the software cause (bit 0). Writing it with bit 1 set returns every register to its R1 state. When both bits are set, the reset wins.
- R11: Config, mask and delay read back the last value written to them. The command address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (triggers clear-on-read for status) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid in the cycle of the read strobe |
| cause_i | input | 9 | One-cycle cause pulses from the data path |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest states to reach from the ports are the overlaps in time. One is a cause pulse that lands in the same cycle as a status read. Another is a second cause that arrives while the coalescing delay is already counting. A third is a watermark pulse that arrives while its arming is in a known state. Directed sequences place each of these events on a chosen edge and count edges until the line rises. A seeded random phase then mixes sparse cause pulses with status reads and write-one-to-clear writes, starting from a command reset so that the bench's model of the arming flags starts in a known state.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

    localparam int NCAUSE = 9;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    // cause bit positions (software decodes these)
    localparam int C_SOFT     = 0;
    localparam int C_RX_PKT   = 1;
    localparam int C_RX_HIGH  = 2;
    localparam int C_RX_EMPTY = 3;
    localparam int C_RX_DMA   = 4;
    localparam int C_TX_PKT   = 5;
    localparam int C_TX_LOW   = 6;
    localparam int C_TX_FULL  = 7;
    localparam int C_TX_DMA   = 8;

    localparam int CFG_EN_BIT   = 0;
    localparam int CMD_INTR_BIT = 0;
    localparam int CMD_RST_BIT  = 1;

    // number of watermark causes gated by hysteresis
    localparam int WM_N = 2;

    typedef logic [NCAUSE-1:0] cause_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG    = 3'd0,
        A_STATUS = 3'd1,
        A_MASK   = 3'd2,
        A_CMD    = 3'd3,
        A_DELAY  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic soft_irq;
        logic soft_rst;
    } cmd_t;

    function automatic cause_t cause_bit(int idx);
        return cause_t'(1) << idx;
    endfunction

    localparam cause_t MASK_RST = cause_bit(C_SOFT) | cause_bit(C_RX_HIGH) |
                                  cause_bit(C_RX_PKT) | cause_bit(C_TX_LOW);

    // watermark cause gated by pair g
    function automatic int wm_level(int g);
        return (g == 0) ? C_RX_HIGH : C_TX_LOW;
    endfunction

    // cause that re-arms pair g
    function automatic int wm_arm(int g);
        return (g == 0) ? C_RX_EMPTY : C_TX_FULL;
    endfunction

    function automatic cmd_t decode_cmd(logic [DATA_W-1:0] wd);
        cmd_t c;
        c.soft_irq = wd[CMD_INTR_BIT];
        c.soft_rst = wd[CMD_RST_BIT];
        return c;
    endfunction

endpackage

// File: rtl/nic_irq_hyst.sv
module nic_irq_hyst (
    input  logic clk_i,
    input  logic rst_i,
    input  logic arm_i,
    input  logic level_i,
    output logic fire_o
);
    logic armed_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            armed_q <= 1'b0;
        else
            armed_q <= arm_i | (armed_q & ~level_i);
    end

    assign fire_o = level_i & armed_q;

    // R5 / R6: firing uses up the arming unless a re-arm came with it
    p_hyst_consume_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        fire_o |=> (!armed_q || $past(arm_i)));

    // R6: no fire without a prior arm pulse since reset
    p_hyst_needs_arm_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!armed_q && !arm_i) |=> !armed_q);

endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import nic_irq_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  cause_t set_i,
    input  logic   rd_clr_i,
    input  logic   w1c_en_i,
    input  cause_t w1c_bits_i,
    output cause_t status_o
);
    cause_t status_q;
    cause_t kept;

    always_comb begin
        if (rd_clr_i)
            kept = '0;
        else if (w1c_en_i)
            kept = status_q & ~w1c_bits_i;
        else
            kept = status_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            status_q <= '0;
        else
            status_q <= kept | set_i;
    end

    assign status_o = status_q;

    // R2: a read leaves only the pulses that came with it
    p_rdclr_keep_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_clr_i && !rst_i) |=> status_q == $past(set_i));

    // R2: a pulse always lands in status
    p_set_sticky_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ((|set_i) && !rst_i) |=> (status_q & $past(set_i)) == $past(set_i));

    // R3: written ones are gone unless re-set
    p_w1c_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (w1c_en_i && !rd_clr_i && !rst_i) |=>
            (status_q & $past(w1c_bits_i & ~set_i)) == '0);

endmodule

// File: rtl/nic_irq_timer.sv
module nic_irq_timer
    import nic_irq_pkg::*;
#(
    parameter int     DLY_W  = 8,
    parameter cause_t URGENT = cause_bit(C_SOFT)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             enable_i,
    input  cause_t           pending_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             irq_o
);
    logic             irq_q;
    logic             running_q;
    logic [DLY_W-1:0] cnt_q;
    logic             any_pend;
    logic             any_urgent;

    assign any_pend   = |pending_i;
    assign any_urgent = |(pending_i & URGENT);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_q     <= 1'b0;
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (!enable_i || !any_pend) begin
            irq_q     <= 1'b0;
            running_q <= 1'b0;
        end else if (irq_q) begin
            irq_q     <= 1'b1;
        end else if (any_urgent) begin
            irq_q     <= 1'b1;
            running_q <= 1'b0;
        end else if (running_q) begin
            if (cnt_q <= DLY_W'(1)) begin
                irq_q     <= 1'b1;
                running_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - DLY_W'(1);
            end
        end else if (delay_i == '0) begin
            irq_q <= 1'b1;
        end else begin
            running_q <= 1'b1;
            cnt_q     <= delay_i;
        end
    end

    assign irq_o = irq_q;

    // R4: line only follows an enabled, non-empty pending set
    p_irq_source_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_q |-> $past(enable_i && any_pend));

    // R4: disabling drops the line
    p_disable_drops_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!enable_i && !rst_i) |=> !irq_q);

    // R7: urgent cause fires on the next edge
    p_urgent_fires_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (enable_i && any_urgent && !rst_i) |=> irq_q);

    // R9: a running delay keeps counting down, never restarts
    p_no_restart_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (running_q && cnt_q > DLY_W'(1) && enable_i && any_pend && !rst_i) |=>
            (irq_q || cnt_q == $past(cnt_q) - DLY_W'(1)));

endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
    import nic_irq_pkg::*;
#(
    parameter int     DLY_W     = 8,
    parameter int     DELAY_RST = 8,
    parameter cause_t URGENT    = cause_bit(C_SOFT)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [NCAUSE-1:0] cause_i,
    output logic              irq_o
);
    localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(DELAY_RST);

    logic             cfg_en_q;
    cause_t           mask_q;
    logic [DLY_W-1:0] delay_q;
    cause_t           status;
    cause_t           raw_set;
    cause_t           set_bits;
    cause_t           pending;
    logic [WM_N-1:0]  wm_fire;
    cmd_t             cmd;
    logic             cmd_wr;
    logic             srst;

    assign cmd    = decode_cmd(reg_wdata_i);
    assign cmd_wr = reg_wr_i && (reg_addr_i == A_CMD);
    assign srst   = rst_i || (cmd_wr && cmd.soft_rst);

    always_comb begin
        raw_set = cause_i;
        if (cmd_wr && cmd.soft_irq)
            raw_set[C_SOFT] = 1'b1;
    end

    // watermark hysteresis pairs
    for (genvar g = 0; g < WM_N; g++) begin : g_wm
        nic_irq_hyst u_hyst (
            .clk_i  (clk_i),
            .rst_i  (srst),
            .arm_i  (raw_set[wm_arm(g)]),
            .level_i(raw_set[wm_level(g)]),
            .fire_o (wm_fire[g])
        );
    end

    always_comb begin
        set_bits = raw_set;
        for (int g = 0; g < WM_N; g++)
            set_bits[wm_level(g)] = wm_fire[g];
    end

    nic_irq_status u_status (
        .clk_i     (clk_i),
        .rst_i     (srst),
        .set_i     (set_bits),
        .rd_clr_i  (reg_rd_i && (reg_addr_i == A_STATUS)),
        .w1c_en_i  (reg_wr_i && (reg_addr_i == A_STATUS)),
        .w1c_bits_i(reg_wdata_i[NCAUSE-1:0]),
        .status_o  (status)
    );

    always_ff @(posedge clk_i) begin
        if (srst) begin
            cfg_en_q <= 1'b0;
            mask_q   <= MASK_RST;
            delay_q  <= DLY_INIT;
        end else if (reg_wr_i) begin
            case (reg_addr_i)
                A_CFG:   cfg_en_q <= reg_wdata_i[CFG_EN_BIT];
                A_MASK:  mask_q   <= reg_wdata_i[NCAUSE-1:0];
                A_DELAY: delay_q  <= reg_wdata_i[DLY_W-1:0];
                default: ;
            endcase
        end
    end

    assign pending = status & mask_q;

    nic_irq_timer #(
        .DLY_W (DLY_W),
        .URGENT(URGENT)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_i    (srst),
        .enable_i (cfg_en_q),
        .pending_i(pending),
        .delay_i  (delay_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_CFG:    reg_rdata_o[CFG_EN_BIT] = cfg_en_q;
            A_STATUS: reg_rdata_o = DATA_W'(status);
            A_MASK:   reg_rdata_o = DATA_W'(mask_q);
            A_DELAY:  reg_rdata_o = DATA_W'(delay_q);
            default:  reg_rdata_o = '0;
        endcase
    end

    // R10: command reset restores the reset state
    p_cmd_reset_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_wr && cmd.soft_rst) |=> (mask_q == MASK_RST && !cfg_en_q && status == '0));

    // R1: line is low right after any reset
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        srst |=> !irq_o);

endmodule

// File: tb/nic_irq_ctrl_test.sv
module nic_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  addr;
    logic        wr, rd;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [8:0]  cause;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam int A_CFG = 0, A_ST = 1, A_MASK = 2, A_CMD = 3, A_DLY = 4;

    always #10 clk = ~clk;

    nic_irq_ctrl uut (
        .clk_i(clk), .rst_i(rst), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .cause_i(cause), .irq_o(irq)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(int a, int d);
        addr = 3'(a); wdata = 16'(d); wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic rreg(int a, output int d);
        addr = 3'(a); rd = 1'b1;
        #1 d = int'(rdata);
        tick();
        rd = 1'b0;
    endtask

    task automatic pulse(int c);
        cause = 9'(c);
        tick();
        cause = '0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 50) begin
            tick();
            n++;
        end
    endtask

    // expected status after one edge, from R2, R3, R5, R6
    function automatic logic [8:0] exp_status(logic [8:0] st, logic [8:0] c,
                                              bit r, bit w, logic [8:0] wd,
                                              bit arx, bit atx);
        logic [8:0] s;
        logic [8:0] set;
        set = c;
        set[2] = c[2] & arx;
        set[6] = c[6] & atx;
        s = r ? 9'h0 : (w ? (st & ~wd) : st);
        return s | set;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int v, n;
        logic [8:0] st;
        bit arx, atx;
        v = int'($urandom(32'd20240611));
        rst = 1'b1; addr = '0; wr = 0; rd = 0; wdata = '0; cause = '0;
        tick(); tick(); tick();
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", int'(irq), 0);
        rreg(A_CFG, v);  check("R1 cfg", v, 0);
        rreg(A_ST, v);   check("R1 status", v, 0);
        rreg(A_MASK, v); check("R1 mask", v, 'h047);
        rreg(A_DLY, v);  check("R1 delay", v, 8);

        // R11 readback
        wreg(A_MASK, 'h1A5); rreg(A_MASK, v); check("R11 mask", v, 'h1A5);
        wreg(A_DLY, 3);      rreg(A_DLY, v);  check("R11 delay", v, 3);
        wreg(A_CFG, 1);      rreg(A_CFG, v);  check("R11 cfg", v, 1);
        rreg(A_CMD, v);      check("R11 cmd reads zero", v, 0);
        wreg(A_CFG, 0);

        // R2 sticky + clear-on-read + same-cycle pulse
        pulse('h002);
        rreg(A_ST, v); check("R2 read", v, 'h002);
        rreg(A_ST, v); check("R2 cleared", v, 0);
        pulse('h002);
        cause = 9'h020;
        rreg(A_ST, v); check("R2 read during pulse", v, 'h002);
        cause = '0;
        rreg(A_ST, v); check("R2 pulse kept", v, 'h020);

        // R3 write-one-to-clear
        pulse('h032);
        wreg(A_ST, 'h112);
        rreg(A_ST, v); check("R3 w1c", v, 'h020);

        // R10 command reset (both bits: reset wins)
        wreg(A_MASK, 'h0F0);
        wreg(A_CFG, 1);
        pulse('h002);
        wreg(A_CMD, 3);
        rreg(A_MASK, v); check("R10 mask restored", v, 'h047);
        rreg(A_ST, v);   check("R10 status cleared", v, 0);
        rreg(A_CFG, v);  check("R10 cfg cleared", v, 0);
        rreg(A_DLY, v);  check("R10 delay restored", v, 8);

        // R5 receive-high hysteresis
        pulse('h004); rreg(A_ST, v); check("R5 disarmed", v, 0);
        pulse('h008); pulse('h004);
        rreg(A_ST, v); check("R5 armed", v, 'h00C);
        pulse('h004); rreg(A_ST, v); check("R5 consumed", v, 0);

        // R6 transmit-low hysteresis
        pulse('h040); rreg(A_ST, v); check("R6 disarmed", v, 0);
        pulse('h080); pulse('h040);
        rreg(A_ST, v); check("R6 armed", v, 'h0C0);
        pulse('h040); rreg(A_ST, v); check("R6 consumed", v, 0);

        // R8 delayed delivery
        wreg(A_MASK, 'h1FF);
        wreg(A_DLY, 3);
        wreg(A_CFG, 1);
        pulse('h002);
        check("R8 not immediate", int'(irq), 0);
        wait_irq(n); check("R8 edges to irq D=3", n, 4);
        rreg(A_ST, v); check("R8 status", v, 'h002);
        tick();
        check("R4 drops when pending empty", int'(irq), 0);

        wreg(A_DLY, 0);
        pulse('h010);
        wait_irq(n); check("R8 edges to irq D=0", n, 1);
        rreg(A_ST, v); tick();

        // R7 urgent via command bit0 (R10 soft cause)
        wreg(A_DLY, 5);
        wreg(A_CMD, 1);
        wait_irq(n); check("R7 urgent edges", n, 1);
        rreg(A_ST, v); check("R10 soft cause bit", v, 'h001);
        tick();

        // R9 no restart
        pulse('h002); tick(); tick();
        cause = 9'h020; tick(); cause = '0;
        wait_irq(n); check("R9 no restart", n + 3, 6);
        rreg(A_ST, v); tick();

        // R9 urgent during delay
        pulse('h002); tick();
        wreg(A_CMD, 1);
        wait_irq(n); check("R9 urgent cuts delay", n, 1);
        rreg(A_ST, v); tick();

        // R4 masked cause does not interrupt
        wreg(A_MASK, 'h0FF);
        pulse('h100);
        for (int i = 0; i < 10; i++) tick();
        check("R4 masked no irq", int'(irq), 0);
        rreg(A_ST, v); check("R4 masked still latched", v, 'h100);

        // R4 enable gating
        wreg(A_MASK, 'h1FF);
        wreg(A_CMD, 1);
        wait_irq(n); check("R4 irq up", int'(irq), 1);
        wreg(A_CFG, 0);
        tick();
        check("R4 disabled drops irq", int'(irq), 0);
        rreg(A_ST, v); check("R4 status kept", v, 'h001);

        // random phase against model
        wreg(A_CMD, 2);
        st = '0; arx = 0; atx = 0;
        for (int i = 0; i < 400; i++) begin
            logic [8:0] c;
            logic [8:0] wd;
            int op;
            c  = 9'($urandom & $urandom & $urandom) & 9'h1FE;
            wd = 9'($urandom);
            op = int'($urandom % 4);
            cause = c;
            addr  = 3'(A_ST);
            wdata = 16'(wd);
            rd = (op == 0);
            wr = (op == 1);
            #1;
            if (op == 0) check("R2 random read", int'(rdata), int'(st));
            tick();
            st  = exp_status(st, c, op == 0, op == 1, wd, arx, atx);
            arx = c[3] | (arx & ~c[2]);
            atx = c[7] | (atx & ~c[6]);
            rd = 0; wr = 0; cause = '0;
        end
        rreg(A_ST, v); check("R3 random final", v, int'(st));

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule